// File: doc/BRIEF.md
# Pipelined Word Substitution Datapath

This block sits behind a word matcher on a stream of 64-bit text chunks, eight ASCII characters each. Every cycle it may take one chunk. A fixed number of cycles later the matcher returns a rule number for that chunk, or zero when nothing matched. The block uses a non-zero rule to read a replacement chunk from an internal table. It outputs either that replacement or the original chunk, with one fixed latency in both cases.

The table has two registered stages, one on the address and one on the read data. The chunk path is delayed so that the original chunk reaches the output selector in the same cycle as the table word. Substitution is allowed only at the start of a word. If the previous chunk did not end in a space, the current chunk continues a longer word and is passed through unchanged. The table is filled through its own write port before the stream starts.

Top module: `word_subst_top`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `out_valid` is 0 and `out_word` is all zeros.
- R2: `out_valid` equals `in_valid` from exactly 10 clock cycles earlier.
- R3: `match_rule` belongs to the chunk presented 7 cycles earlier. When a valid chunk has a non-zero rule n and the chunk before it ended in a space, the output chunk is table entry n-1. Rule 1 reads entry 0 and rule 1024 reads entry 1023.
- R4: A valid chunk whose rule is 0 is output unchanged. The table is not read for it.
- R5: When the previous valid chunk has a top byte (bits 63:56) other than 0x20, the current chunk is output unchanged, whatever its rule.
- R6: After reset, and after any cycle with `in_valid` low, the next valid chunk is treated as if the chunk before it ended in a space. It can therefore be replaced.
- R7: A write with `tbl_wr_en` high stores `tbl_wr_data` at `tbl_wr_addr`. Later substitutions that read that entry return the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 10 | Table write index |
| tbl_wr_data | input | 64 | Table write word |
| in_valid | input | 1 | Input chunk present |
| in_word | input | 64 | Input chunk, top byte is the last character |
| match_rule | input | 11 | Rule number for the chunk seven cycles earlier, 0 means no match |
| out_valid | output | 1 | Output chunk present |
| out_word | output | 64 | Replacement or original chunk |

## Verification
The assertions assume three things about the inputs. `match_rule` stays within 0 to 1024. It is zero in every cycle whose matching chunk, seven cycles earlier, was not valid. No table entry is rewritten while a substitution that reads it is in flight. The stimulus meets these conditions in the following way. It fills the whole table before any chunk is sent. It draws rules only from 1 to 1024 or 0. It drives zero on `match_rule` for every gap cycle, replaying each rule exactly seven cycles after its chunk.

// File: rtl/word_subst_pkg.sv
// Shared types and constants for the word substitution datapath.
// Assumes 8-bit ASCII characters packed eight to a 64-bit chunk,
// with the last character of the chunk in the top byte.
package word_subst_pkg;
    localparam int CHAR_W   = 8;
    localparam int WORD_W   = 64;
    localparam logic [CHAR_W-1:0] SPACE_CHAR = 8'h20;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/subst_delay_line.sv
// Fixed-length register chain of W bits and N stages.
// Assumes N >= 1. Every stage clears on reset.
module subst_delay_line #(
    parameter int W = 1,
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [N-1:0][W-1:0] stg;

    // shift the chain by one stage each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < N; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[N-1];
endmodule

// File: rtl/subst_table.sv
// Replacement word store with a registered read address and registered
// read data, so a read takes two cycles. The address register holds its
// value when no read is requested. Write and read ports are independent.
// Assumes no write hits an entry while a read of it is in flight.
module subst_table #(
    parameter int ADDR_W = 10,
    parameter int W      = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0]      mem [DEPTH];
    logic [ADDR_W-1:0] addr_q;

    // store words from the write port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // capture the read index only for real lookups
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (rd_en) begin
            addr_q <= rd_addr;
        end
    end

    // register the read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[addr_q];
        end
    end
endmodule

// File: rtl/subst_select.sv
// Output stage. It tracks whether the previous aligned chunk ended in a
// space and registers either the table word or the aligned original.
// A gap in valid chunks, or reset, counts as "ended in a space".
module subst_select
    import word_subst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  al_valid,
    input  word_t al_word,
    input  logic  al_hit,
    input  word_t tbl_word,
    output logic  out_valid,
    output word_t out_word
);
    logic prev_space;
    logic take_tbl;

    // remember whether the last aligned slot allows a new word to start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_space <= 1'b1;
        end else begin
            prev_space <= !al_valid || (al_word[WORD_W-1 -: CHAR_W] == SPACE_CHAR);
        end
    end

    // decide whether this slot is substituted
    always_comb begin
        take_tbl = al_valid && al_hit && prev_space;
    end

    // registered output multiplexer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= al_valid;
            out_word  <= take_tbl ? tbl_word : al_word;
        end
    end
endmodule

// File: rtl/word_subst_top.sv
// Word substitution datapath. The match result for a chunk arrives
// MATCH_LAT cycles after the chunk. A non-zero result n reads table entry
// n-1 over two cycles. The chunk and its valid bit are delayed to meet the
// table output, then one output register follows.
// Assumes match_rule <= 2**ADDR_W and zero for cycles without a chunk.
module word_subst_top
    import word_subst_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int MATCH_LAT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr_en,
    input  logic [ADDR_W-1:0] tbl_wr_addr,
    input  logic [63:0]       tbl_wr_data,
    input  logic              in_valid,
    input  logic [63:0]       in_word,
    input  logic [ADDR_W:0]   match_rule,
    output logic              out_valid,
    output logic [63:0]       out_word
);
    localparam int RULE_W  = ADDR_W + 1;
    localparam int TBL_LAT = 2;
    localparam int ALIGN   = MATCH_LAT + TBL_LAT;

    logic              rule_hit;
    logic [RULE_W-1:0] rule_m1;
    logic [1:0]        hit_q;
    logic              al_valid;
    word_t             al_word;
    word_t             tbl_word;

    // decode the rule into a hit flag and a table index
    always_comb begin
        rule_hit = (match_rule != '0);
        rule_m1  = match_rule - RULE_W'(1);
    end

    // carry the hit flag alongside the two table stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= '0;
        end else begin
            hit_q <= {hit_q[0], rule_hit};
        end
    end

    subst_delay_line #(.W(1), .N(ALIGN)) i_vdly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (in_valid),
        .q     (al_valid)
    );

    subst_delay_line #(.W(WORD_W), .N(ALIGN)) i_wdly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (in_word),
        .q     (al_word)
    );

    subst_table #(.ADDR_W(ADDR_W), .W(WORD_W)) i_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_en   (rule_hit),
        .rd_addr (rule_m1[ADDR_W-1:0]),
        .rd_data (tbl_word)
    );

    subst_select i_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .al_valid  (al_valid),
        .al_word   (al_word),
        .al_hit    (hit_q[1]),
        .tbl_word  (tbl_word),
        .out_valid (out_valid),
        .out_word  (out_word)
    );
endmodule

// File: rtl/word_subst_chk.sv
// Property checker for word_subst_top, attached by bind. A saturating
// count of cycles since reset keeps every $past window inside the
// time after reset.
module word_subst_chk #(
    parameter int ADDR_W    = 10,
    parameter int MATCH_LAT = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [63:0]     in_word,
    input logic [ADDR_W:0] match_rule,
    input logic            out_valid,
    input logic [63:0]     out_word
);
    localparam int LAT = MATCH_LAT + 3;

    logic [4:0] since_rst;

    // count cycles since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 5'd31) begin
            since_rst <= since_rst + 5'd1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 5'd0) |-> (!out_valid && out_word == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst > 5'(LAT)) |-> (out_valid == $past(in_valid, 10)));

    // R4
    no_match_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst > 5'(LAT) && out_valid && $past(match_rule, 3) == '0)
        |-> (out_word == $past(in_word, 10)));

    // R5
    continuation_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst > 5'(LAT) && out_valid && $past(in_valid, 11)
         && $past(in_word[63:56], 11) != 8'h20)
        |-> (out_word == $past(in_word, 10)));
endmodule

bind word_subst_top word_subst_chk #(.ADDR_W(ADDR_W), .MATCH_LAT(MATCH_LAT)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .match_rule (match_rule),
    .out_valid  (out_valid),
    .out_word   (out_word)
);

// File: tb/test_word_subst_top.sv
module test_word_subst_top;
    localparam int NCYC  = 3000;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [9:0]  tbl_wr_addr = '0;
    logic [63:0] tbl_wr_data = '0;
    logic        in_valid = 1'b0;
    logic [63:0] in_word = '0;
    logic [10:0] match_rule = '0;
    logic        out_valid;
    logic [63:0] out_word;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic        sv [NCYC];
    logic [63:0] sw [NCYC];
    logic [10:0] sr [NCYC];

    always #5 clk = ~clk;

    word_subst_top i_word_subst_top (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .in_valid(in_valid), .in_word(in_word), .match_rule(match_rule),
        .out_valid(out_valid), .out_word(out_word)
    );

    function automatic logic [63:0] tbl_val(input int i);
        return {16'(i), 16'(i * 7 + 3), ~16'(i), 16'hC0DE ^ 16'(i)};
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic gen_stim();
        for (int k = 0; k < NCYC; k++) begin
            logic [63:0] w;
            w = {$urandom, $urandom};
            if ($urandom_range(0, 1) == 0) w[63:56] = 8'h20;
            else w[63:56] = 8'(8'h61 + $urandom_range(0, 25));
            sv[k] = ($urandom_range(0, 7) != 0);
            sw[k] = w;
            sr[k] = sv[k] ? (($urandom_range(0, 1) == 0) ? 11'd0 : 11'($urandom_range(1, DEPTH))) : 11'd0;
        end
        // directed: R6 first of burst with rule 1 (entry 0)
        sv[0] = 1; sw[0][63:56] = 8'h6B; sr[0] = 11'd1;
        // R5 continuation with rule 1024
        sv[1] = 1; sw[1][63:56] = 8'h20; sr[1] = 11'd1024;
        // gap, then R6 first after gap with rule 1024 (entry 1023)
        sv[2] = 0; sr[2] = 0;
        sv[3] = 1; sw[3][63:56] = 8'h20; sr[3] = 11'd1024;
        // R4 rule 0 after a space
        sv[4] = 1; sw[4][63:56] = 8'h71; sr[4] = 11'd0;
        // R5 previous ended in 'q'
        sv[5] = 1; sw[5][63:56] = 8'h20; sr[5] = 11'd5;
        // R3 previous ended in space
        sv[6] = 1; sr[6] = 11'd77;
    endtask

    task automatic check_slot(input int j);
        logic prev_sp;
        logic [63:0] exp;
        string tag;
        check64("R2", 64'(out_valid), 64'(sv[j]));
        if (sv[j]) begin
            prev_sp = (j == 0) || !sv[j-1] || (sw[j-1][63:56] == 8'h20);
            if (sr[j] == 0) tag = "R4";
            else if (!prev_sp) tag = "R5";
            else if (j == 0 || !sv[j-1]) tag = "R6";
            else tag = "R3/R7";
            exp = (sr[j] != 0 && prev_sp) ? tbl_val(int'(sr[j]) - 1) : sw[j];
            check64(tag, out_word, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd4417));
        gen_stim();
        repeat (5) @(negedge clk);
        // R1 outputs quiet under reset
        check64("R1", 64'(out_valid), 64'd0);
        check64("R1", out_word, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R1", 64'(out_valid), 64'd0);
        check64("R1", out_word, 64'd0);
        // R7 fill every table entry
        for (int i = 0; i < DEPTH; i++) begin
            tbl_wr_en = 1'b1;
            tbl_wr_addr = 10'(i);
            tbl_wr_data = tbl_val(i);
            @(negedge clk);
        end
        tbl_wr_en = 1'b0;
        check64("R2", 64'(out_valid), 64'd0);
        for (int k = 0; k < NCYC + 12; k++) begin
            if (k >= 10 && k - 10 < NCYC) check_slot(k - 10);
            in_valid   = (k < NCYC) ? sv[k] : 1'b0;
            in_word    = (k < NCYC) ? sw[k] : 64'd0;
            match_rule = (k >= 7 && k - 7 < NCYC) ? sr[k-7] : 11'd0;
            @(negedge clk);
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end
endmodule